// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address. It walks a radix tree of translation tables that has four levels. A root base input gives the 40-bit frame number of the top table. For each level, the walker builds an entry address from the current table frame and one 9-bit slice of the virtual address. It reads the 64-bit entry over a simple memory port and checks the entry before it moves on.

Each entry is checked for presence and for access rights against the request's mode (user or supervisor) and access type (read or write). When an entry's accessed flag is clear, the walker writes the entry back with the flag set before it continues. On a write, a clear dirty flag in the leaf entry is handled the same way. The walk ends with one `done` pulse, which carries either the physical address or a fault cause together with the level at which the fault was found.

One translation is in flight at a time. The memory port has one request outstanding at most, and the response may come back after any number of cycles.

Top module: `pt_walker`

## Requirements
- R1: The entry address at each level is `{table_frame[39:0], index[8:0], 3'b000}`. The first level uses `root_base`; every later level uses bits [51:12] of the entry read at the level above.
- R2: The table index for level 0 is taken from vaddr[47:39], for level 1 from [38:30], for level 2 from [29:21] and for level 3 from [20:12]. A walk with no faults and no flag updates issues exactly four reads, in level order from 0 to 3.
- R3: An entry with bit 0 (present) clear ends the walk. `fault_cause` is 2'b01 and `fault_level` is the level of that entry (0 to 3). No further requests are issued.
- R4: A user-mode request (`req_user`=1) that meets an entry at any level with bit 2 (user-allowed) clear ends the walk with `fault_cause` 2'b10 at that level. A supervisor-mode request ignores bit 2.
- R5: A write request (`req_write`=1) that meets an entry at any level with bit 1 (writable) clear ends the walk with `fault_cause` 2'b10 at that level. A read request ignores bit 1.
- R6: An entry that passes its checks with bit 5 (accessed) clear is written back to the same address with bit 5 set and all other bits unchanged. This happens before the next level is read, on reads and on writes alike.
- R7: On a write request, a leaf entry (level 3) with bit 6 (dirty) clear is written back with bits 6 and 5 set. A read request never sets bit 6. An entry that needs no flag changes is not written.
- R8: A walk that faults issues no write-back for the faulting entry, and no request after its read.
- R9: A walk with no faults ends with `fault_cause` 2'b00 and `done_paddr` = {leaf entry bits [51:12], vaddr[11:0]}.
- R10: `busy` is low after reset and rises in the cycle after `req_valid` is accepted. It stays high up to and including the single cycle in which `done` is high, then drops. `req_valid` is ignored while `busy` is high.
- R11: The walker has one memory request outstanding at most. Each request, read or write, is a one-cycle `mem_req_valid` pulse and waits for exactly one `mem_rsp_valid`, which may arrive in any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 40 | Frame number of the top-level table |
| req_valid | input | 1 | Start a translation (sampled only while idle) |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| busy | output | 1 | A translation is in progress |
| done | output | 1 | One-cycle pulse: result outputs are valid |
| done_paddr | output | 52 | Translated physical address (zero on a fault) |
| fault_cause | output | 2 | 00 none, 01 not present, 10 protection |
| fault_level | output | 2 | Level at which the fault was detected |
| mem_req_valid | output | 1 | One-cycle memory request pulse |
| mem_req_write | output | 1 | 1 = write-back of an entry, 0 = entry read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_req_wdata | output | 64 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Response to the outstanding request |
| mem_rsp_rdata | input | 64 | Entry data for a read response |

## Verification
The hardest state to reach is a walk where flag write-backs mix with fault checks on the same entry. One case is a read-only leaf with a clear accessed flag under a write: the write-back must not go out. Another is a leaf whose accessed flag was set by an earlier walk but whose dirty flag is still clear. The bench reaches these by sending the same virtual address several times in sequence with different access types and modes. The stored tables therefore carry the updates from earlier walks, and the bench's reference model rebuilds the expected request list from that live memory image before every walk. Response latency and requests made while busy are varied on top of that.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_WAIT = 3'd2,
        ST_WB_REQ  = 3'd3,
        ST_WB_WAIT = 3'd4,
        ST_DONE    = 3'd5
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_PROT   = 2'b10
    } flt_cause_e;

    // Flag positions inside an entry
    localparam int unsigned BIT_PRESENT  = 0;
    localparam int unsigned BIT_WRITABLE = 1;
    localparam int unsigned BIT_USER     = 2;
    localparam int unsigned BIT_ACCESSED = 5;
    localparam int unsigned BIT_DIRTY    = 6;

endpackage

// File: rtl/pt_index_sel.sv
// Picks the table index for the current level and forms the entry address.
module pt_index_sel #(
    parameter int unsigned LEVELS  = 4,
    parameter int unsigned IDX_W   = 9,
    parameter int unsigned OFF_W   = 12,
    parameter int unsigned FRAME_W = 40,
    parameter int unsigned LVL_W   = 2,
    parameter int unsigned PA_W    = FRAME_W + OFF_W
) (
    input  logic [LEVELS*IDX_W-1:0] vpn,
    input  logic [LVL_W-1:0]        level,
    input  logic [FRAME_W-1:0]      table_frame,
    output logic [PA_W-1:0]         entry_addr
);
    logic [IDX_W-1:0] idx_by_lvl [LEVELS];
    logic [IDX_W-1:0] idx_cur;

    // Level 0 takes the most significant slice.
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign idx_by_lvl[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
    end

    assign idx_cur = idx_by_lvl[level];

    // Entries are eight bytes wide, hence the shift by three.
    assign entry_addr = {table_frame, {OFF_W{1'b0}}} | PA_W'({idx_cur, 3'b000});

endmodule

// File: rtl/pt_entry_eval.sv
// Checks one entry against the request and computes its updated image.
module pt_entry_eval
    import pt_walker_pkg::*;
#(
    parameter int unsigned ENT_W   = 64,
    parameter int unsigned OFF_W   = 12,
    parameter int unsigned FRAME_W = 40
) (
    input  logic [ENT_W-1:0]   entry,
    input  logic               is_leaf,
    input  logic               is_write,
    input  logic               is_user,
    output logic               absent,
    output logic               prot,
    output logic               needs_wb,
    output logic [ENT_W-1:0]   wb_entry,
    output logic [FRAME_W-1:0] next_frame
);
    always_comb begin
        absent   = !entry[BIT_PRESENT];
        prot     = (is_user && !entry[BIT_USER]) || (is_write && !entry[BIT_WRITABLE]);
        wb_entry = entry;
        wb_entry[BIT_ACCESSED] = 1'b1;
        if (is_leaf && is_write) begin
            wb_entry[BIT_DIRTY] = 1'b1;
        end
        needs_wb   = (wb_entry != entry);
        next_frame = entry[OFF_W +: FRAME_W];
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int unsigned LEVELS  = 4,
    parameter int unsigned IDX_W   = 9,
    parameter int unsigned OFF_W   = 12,
    parameter int unsigned FRAME_W = 40,
    parameter int unsigned ENT_W   = 64,
    localparam int unsigned VA_W   = OFF_W + LEVELS * IDX_W,
    localparam int unsigned PA_W   = FRAME_W + OFF_W,
    localparam int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] root_base,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    input  logic               req_user,
    output logic               busy,
    output logic               done,
    output logic [PA_W-1:0]    done_paddr,
    output logic [1:0]         fault_cause,
    output logic [LVL_W-1:0]   fault_level,
    output logic               mem_req_valid,
    output logic               mem_req_write,
    output logic [PA_W-1:0]    mem_req_addr,
    output logic [ENT_W-1:0]   mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [ENT_W-1:0]   mem_rsp_rdata
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    typedef struct packed {
        walk_state_e        st;
        logic [VA_W-1:0]    va;
        logic               wr;
        logic               usr;
        logic [FRAME_W-1:0] base;
        logic [LVL_W-1:0]   lvl;
        logic [ENT_W-1:0]   ent;
        logic [PA_W-1:0]    paddr;
        flt_cause_e         cause;
        logic [LVL_W-1:0]   flt_lvl;
    } walk_t;

    walk_t s_d, s_q;

    logic [PA_W-1:0]    cur_addr;
    logic               is_leaf;
    logic               ev_absent;
    logic               ev_prot;
    logic               ev_needs_wb;
    logic [ENT_W-1:0]   ev_wb_entry;
    logic [FRAME_W-1:0] ev_next_frame;
    logic               adv_go;
    logic [FRAME_W-1:0] adv_frame;

    assign is_leaf = (s_q.lvl == LAST_LVL);

    pt_index_sel #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W),
        .FRAME_W(FRAME_W),
        .LVL_W  (LVL_W),
        .PA_W   (PA_W)
    ) u_index_sel (
        .vpn        (s_q.va[VA_W-1:OFF_W]),
        .level      (s_q.lvl),
        .table_frame(s_q.base),
        .entry_addr (cur_addr)
    );

    pt_entry_eval #(
        .ENT_W  (ENT_W),
        .OFF_W  (OFF_W),
        .FRAME_W(FRAME_W)
    ) u_entry_eval (
        .entry     (mem_rsp_rdata),
        .is_leaf   (is_leaf),
        .is_write  (s_q.wr),
        .is_user   (s_q.usr),
        .absent    (ev_absent),
        .prot      (ev_prot),
        .needs_wb  (ev_needs_wb),
        .wb_entry  (ev_wb_entry),
        .next_frame(ev_next_frame)
    );

    always_comb begin
        s_d       = s_q;
        adv_go    = 1'b0;
        adv_frame = s_q.base;

        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st   = ST_RD_REQ;
                    s_d.va   = req_vaddr;
                    s_d.wr   = req_write;
                    s_d.usr  = req_user;
                    s_d.base = root_base;
                    s_d.lvl  = '0;
                end
            end
            ST_RD_REQ: s_d.st = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ev_absent) begin
                        s_d.st      = ST_DONE;
                        s_d.cause   = FLT_ABSENT;
                        s_d.flt_lvl = s_q.lvl;
                        s_d.paddr   = '0;
                    end else if (ev_prot) begin
                        s_d.st      = ST_DONE;
                        s_d.cause   = FLT_PROT;
                        s_d.flt_lvl = s_q.lvl;
                        s_d.paddr   = '0;
                    end else if (ev_needs_wb) begin
                        s_d.ent = ev_wb_entry;
                        s_d.st  = ST_WB_REQ;
                    end else begin
                        adv_go    = 1'b1;
                        adv_frame = ev_next_frame;
                    end
                end
            end
            ST_WB_REQ: s_d.st = ST_WB_WAIT;
            ST_WB_WAIT: begin
                if (mem_rsp_valid) begin
                    adv_go    = 1'b1;
                    adv_frame = s_q.ent[OFF_W +: FRAME_W];
                end
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase

        if (adv_go) begin
            if (is_leaf) begin
                s_d.st      = ST_DONE;
                s_d.paddr   = {adv_frame, s_q.va[OFF_W-1:0]};
                s_d.cause   = FLT_NONE;
                s_d.flt_lvl = '0;
            end else begin
                s_d.st   = ST_RD_REQ;
                s_d.base = adv_frame;
                s_d.lvl  = s_q.lvl + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy          = (s_q.st != ST_IDLE);
    assign done          = (s_q.st == ST_DONE);
    assign done_paddr    = s_q.paddr;
    assign fault_cause   = s_q.cause;
    assign fault_level   = s_q.flt_lvl;
    assign mem_req_valid = (s_q.st == ST_RD_REQ) || (s_q.st == ST_WB_REQ);
    assign mem_req_write = (s_q.st == ST_WB_REQ);
    assign mem_req_addr  = cur_addr;
    assign mem_req_wdata = s_q.ent;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int unsigned VA_W  = 48,
    parameter int unsigned PA_W  = 52,
    parameter int unsigned ENT_W = 64,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned LVL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             busy,
    input logic             done,
    input logic [PA_W-1:0]  done_paddr,
    input logic [1:0]       fault_cause,
    input logic             mem_req_valid,
    input logic             mem_req_write,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic [ENT_W-1:0] mem_req_wdata,
    input logic             mem_rsp_valid
);
    logic            outstanding;
    logic [PA_W-1:0] last_rd_addr;
    logic [OFF_W-1:0] off_lat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding  <= 1'b0;
            last_rd_addr <= '0;
            off_lat      <= '0;
        end else begin
            if (mem_req_valid) begin
                outstanding <= 1'b1;
            end else if (mem_rsp_valid) begin
                outstanding <= 1'b0;
            end
            if (mem_req_valid && !mem_req_write) begin
                last_rd_addr <= mem_req_addr;
            end
            if (req_valid && !busy) begin
                off_lat <= req_vaddr[OFF_W-1:0];
            end
        end
    end

    p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !outstanding);

    p_rsp_matched_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> outstanding);

    p_req_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_wb_accessed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata[5] && mem_req_addr == last_rd_addr));

    p_leaf_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_cause == 2'b00) |-> (done_paddr[OFF_W-1:0] == off_lat));

endmodule

bind pt_walker pt_walker_chk #(
    .VA_W (VA_W),
    .PA_W (PA_W),
    .ENT_W(ENT_W),
    .OFF_W(OFF_W),
    .LVL_W(LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .busy         (busy),
    .done         (done),
    .done_paddr   (done_paddr),
    .fault_cause  (fault_cause),
    .mem_req_valid(mem_req_valid),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [39:0] root_base;
    logic        req_valid;
    logic [47:0] req_vaddr;
    logic        req_write;
    logic        req_user;
    logic        busy, done;
    logic [51:0] done_paddr;
    logic [1:0]  fault_cause, fault_level;
    logic        mem_req_valid, mem_req_write;
    logic [51:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_rdata;

    always #2.5 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
        .busy(busy), .done(done), .done_paddr(done_paddr),
        .fault_cause(fault_cause), .fault_level(fault_level),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    int checks = 0;
    int fails  = 0;
    int rsp_lat = 0;
    bit finished = 1'b0;
    logic [63:0]  mem [logic [51:0]];
    logic [116:0] expq [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ent(input logic [39:0] frame, input logic [11:0] flags);
        return {12'h000, frame, flags};
    endfunction

    function automatic logic [47:0] mkva(input logic [8:0] a, input logic [8:0] b,
                                         input logic [8:0] c, input logic [8:0] d,
                                         input logic [11:0] off);
        return {a, b, c, d, off};
    endfunction

    task automatic put(input logic [39:0] tbl, input logic [8:0] idx, input logic [63:0] v);
        mem[{tbl, idx, 3'b000}] = v;
    endtask

    // Behavioural reference: expected request list and result from the live memory image.
    task automatic model(input logic [47:0] va, input bit wr, input bit usr,
                         output logic [1:0] cause, output logic [1:0] lvl, output logic [51:0] pa);
        logic [39:0] base;
        base  = root_base;
        cause = 2'b00;
        lvl   = 2'b00;
        pa    = '0;
        for (int l = 0; l < 4; l++) begin
            logic [8:0]  ix;
            logic [51:0] a;
            logic [63:0] e, u;
            ix = va[12 + 9*(3-l) +: 9];
            a  = {base, ix, 3'b000};
            e  = mem.exists(a) ? mem[a] : 64'h0;
            expq.push_back({1'b0, a, 64'h0});
            if (!e[0]) begin
                cause = 2'b01; lvl = 2'(l); return;
            end
            if ((usr && !e[2]) || (wr && !e[1])) begin
                cause = 2'b10; lvl = 2'(l); return;
            end
            u = e | 64'h20;
            if (l == 3 && wr) u = u | 64'h40;
            if (u != e) expq.push_back({1'b1, a, u});
            base = e[51:12];
            if (l == 3) pa = {e[51:12], va[11:0]};
        end
    endtask

    // Memory responder: checks every request against the model's list.
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                logic [116:0] got, e;
                logic [63:0]  rd;
                got = {mem_req_write, mem_req_addr, mem_req_wdata};
                if (expq.size() == 0) begin
                    chk(1'b0, "R8", "unexpected memory request", {12'h0, mem_req_addr}, 64'h0);
                end else begin
                    e = expq.pop_front();
                    chk(got[116] == e[116], "R6", "request kind (write)", {63'h0, got[116]}, {63'h0, e[116]});
                    chk(got[115:64] == e[115:64], "R1", "entry address", {12'h0, got[115:64]}, {12'h0, e[115:64]});
                    if (e[116]) chk(got[63:0] == e[63:0], "R7", "write-back data", got[63:0], e[63:0]);
                end
                if (mem_req_write) mem[mem_req_addr] = mem_req_wdata;
                rd = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
                repeat (rsp_lat) @(negedge clk);
                @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = rd;
            end
        end
    end

    task automatic walk(input logic [47:0] va, input bit wr, input bit usr,
                        input string tag, input bit poke);
        logic [1:0]  ec, el;
        logic [51:0] ep;
        int n;
        n = 0;
        model(va, wr, usr, ec, el, ep);
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (done !== 1'b1 && n < 2000) begin
            chk(busy === 1'b1, "R10", "busy during walk", {63'h0, busy}, 64'h1);
            if (poke && n == 2) begin
                req_valid = 1'b1; req_vaddr = ~va; req_write = ~wr;
            end
            if (poke && n == 3) req_valid = 1'b0;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(done === 1'b1, tag, "done reached", {63'h0, done}, 64'h1);
        chk(busy === 1'b1, "R10", "busy with done", {63'h0, busy}, 64'h1);
        chk(fault_cause === ec, tag, "fault cause", {62'h0, fault_cause}, {62'h0, ec});
        if (ec != 2'b00)
            chk(fault_level === el, tag, "fault level", {62'h0, fault_level}, {62'h0, el});
        else
            chk(done_paddr === ep, tag, "physical address", {12'h0, done_paddr}, {12'h0, ep});
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R10", "idle after done", {62'h0, busy, done}, 64'h0);
        chk(expq.size() == 0, tag, "expected requests left over", 64'(expq.size()), 64'h0);
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R11 watchdog expired actual=hung expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;
        root_base = 40'h10;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && mem_req_valid === 1'b0, "R10", "reset outputs",
            {61'h0, busy, done, mem_req_valid}, 64'h0);
        chk(fault_cause === 2'b00, "R10", "reset fault cause", {62'h0, fault_cause}, 64'h0);
        rst_n = 1'b1;

        // Base mapping: all flags set
        put(40'h10, 9'd1, ent(40'h20, 12'h027));
        put(40'h20, 9'd2, ent(40'h30, 12'h027));
        put(40'h30, 9'd3, ent(40'h40, 12'h027));
        put(40'h40, 9'd4, ent(40'hABCDE, 12'h067));
        walk(mkva(1, 2, 3, 4, 12'h5A5), 1'b0, 1'b1, "R2", 1'b0);
        walk(mkva(1, 2, 3, 4, 12'h5A5), 1'b0, 1'b1, "R9", 1'b0);
        chk(done_paddr === 52'h0_00AB_CDE5_A5 >> 0 && done_paddr === {40'hABCDE, 12'h5A5}, "R9",
            "leaf frame joined with offset", {12'h0, done_paddr}, {12'h0, 40'hABCDE, 12'h5A5});
        walk(mkva(1, 2, 3, 4, 12'h001), 1'b1, 1'b1, "R7", 1'b0);

        // Leaf with accessed and dirty clear
        put(40'h40, 9'd5, ent(40'h12345, 12'h007));
        walk(mkva(1, 2, 3, 5, 12'h010), 1'b0, 1'b1, "R6", 1'b0);
        chk(mem[{40'h40, 9'd5, 3'b000}] === ent(40'h12345, 12'h027), "R7", "read leaves dirty clear",
            mem[{40'h40, 9'd5, 3'b000}], ent(40'h12345, 12'h027));
        walk(mkva(1, 2, 3, 5, 12'h020), 1'b1, 1'b1, "R7", 1'b0);
        walk(mkva(1, 2, 3, 5, 12'h030), 1'b1, 1'b1, "R7", 1'b0);

        // Intermediate entry with accessed clear
        put(40'h30, 9'd6, ent(40'h50, 12'h007));
        put(40'h50, 9'd7, ent(40'h777, 12'h067));
        walk(mkva(1, 2, 6, 7, 12'hFED), 1'b0, 1'b1, "R6", 1'b0);

        // Not-present at several levels
        walk(mkva(9, 0, 0, 0, 12'h0), 1'b0, 1'b0, "R3", 1'b0);
        walk(mkva(1, 13, 0, 0, 12'h0), 1'b1, 1'b0, "R3", 1'b0);
        walk(mkva(1, 2, 3, 8, 12'h0), 1'b0, 1'b1, "R3", 1'b0);

        // Supervisor-only entries
        put(40'h40, 9'd10, ent(40'h5555, 12'h023));
        walk(mkva(1, 2, 3, 10, 12'h111), 1'b0, 1'b1, "R4", 1'b0);
        walk(mkva(1, 2, 3, 10, 12'h111), 1'b0, 1'b0, "R4", 1'b0);
        put(40'h20, 9'd11, ent(40'h60, 12'h023));
        put(40'h60, 9'd0, ent(40'h61, 12'h027));
        walk(mkva(1, 11, 0, 0, 12'h0), 1'b0, 1'b1, "R4", 1'b0);

        // Read-only entries; accessed clear must stay clear on a faulting write
        put(40'h40, 9'd12, ent(40'h2222, 12'h005));
        walk(mkva(1, 2, 3, 12, 12'h0AB), 1'b1, 1'b1, "R5", 1'b0);
        chk(mem[{40'h40, 9'd12, 3'b000}] === ent(40'h2222, 12'h005), "R8", "faulting entry unchanged",
            mem[{40'h40, 9'd12, 3'b000}], ent(40'h2222, 12'h005));
        walk(mkva(1, 2, 3, 12, 12'h0AB), 1'b0, 1'b1, "R5", 1'b0);
        put(40'h10, 9'd14, ent(40'h70, 12'h025));
        walk(mkva(14, 0, 0, 0, 12'h0), 1'b1, 1'b0, "R5", 1'b0);

        // Response latency
        rsp_lat = 3;
        walk(mkva(1, 2, 3, 4, 12'h777), 1'b0, 1'b0, "R11", 1'b0);
        rsp_lat = 7;
        put(40'h40, 9'd20, ent(40'h4444, 12'h003));
        walk(mkva(1, 2, 3, 20, 12'h321), 1'b1, 1'b0, "R11", 1'b0);
        rsp_lat = 0;

        // Request while busy is ignored
        walk(mkva(1, 2, 3, 4, 12'h0C3), 1'b0, 1'b1, "R10", 1'b1);

        // All-ones index and offset
        put(40'h10, 9'd511, ent(40'h80, 12'h027));
        put(40'h80, 9'd511, ent(40'h81, 12'h027));
        put(40'h81, 9'd511, ent(40'h82, 12'h027));
        put(40'h82, 9'd511, ent(40'hFF_FFFF_FFFF, 12'h067));
        walk(48'hFFFF_FFFF_FFFF, 1'b1, 1'b1, "R1", 1'b0);
        chk(done_paddr === 52'hF_FFFF_FFFF_FFFF, "R1", "top-of-range address",
            {12'h0, done_paddr}, {12'h0, 52'hF_FFFF_FFFF_FFFF});

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule